// File: doc/BRIEF.md
# Segment Address Translator

This block turns virtual addresses into physical addresses using a small table of segment descriptors that belong to the running process. Each descriptor has four fields: a valid flag, the first virtual address the segment covers, its length, and the physical address where the segment is placed. A lookup checks the address against every valid descriptor at once. If a descriptor covers the address, the address is moved into physical memory: the segment start is subtracted and the placement base is added. If no descriptor covers it, the block raises a fault and returns the offending virtual address, so that software can decide what happens next.

Software loads descriptors through a one-cycle write port. A descriptor whose start is zero gives the simple relocation-register scheme. In that case an address is accepted when it is below the length, and it is moved by adding the base. Every lookup gets a registered response exactly one cycle after the request.

Top module: `seg_xlate`

## Requirements
- R1: While reset is held, and after it is released, the response outputs are all zero and every descriptor is invalid. A lookup made straight after reset therefore faults.
- R2: A request sampled on a rising edge produces a response with rsp_valid=1 right after that edge. A cycle with no request produces rsp_valid=0 and drives every other response output to zero.
- R3: Descriptor i covers address va only when start <= va < start+bound. The lower limit is included and the upper limit is excluded, so a bound of zero covers nothing.
- R4: On a hit, rsp_paddr = (va - start + base) mod 2^ADDR_W, rsp_fault = 0, and rsp_fault_vaddr = 0.
- R5: start+bound is formed without wrapping. A segment that runs past the top of the address space covers the addresses from start up to all-ones, and never covers any low address.
- R6: A descriptor whose valid flag is 0 never matches, whatever its other fields hold.
- R7: When several descriptors match, the one with the lowest index wins, and rsp_seg carries that index.
- R8: When no valid descriptor matches: rsp_fault = 1, rsp_paddr = 0, rsp_fault_vaddr = the requested address, and rsp_seg = 0.
- R9: A descriptor with start 0 acts as base-and-bound: va < bound hits with paddr = va + base, and va >= bound does not match.
- R10: A write with wr_en=1 replaces all four fields of the descriptor selected by wr_idx and leaves every other descriptor unchanged. A request made in the same cycle as the write still sees the old contents. A request in the next cycle sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | IDX_W | Descriptor slot to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_start | input | ADDR_W | Segment first virtual address |
| wr_bound | input | ADDR_W | Segment length in bytes |
| wr_base | input | ADDR_W | Segment physical placement |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | ADDR_W | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | No segment covers the address |
| rsp_paddr | output | ADDR_W | Translated physical address, zero on fault |
| rsp_fault_vaddr | output | ADDR_W | Faulting virtual address, zero on hit |
| rsp_seg | output | IDX_W | Index of the winning descriptor |

## Verification
The bench probes each segment edge: the byte before the start, the start itself, the last covered byte, and the byte one past the end. A design that included the upper limit, or excluded the lower one, would hit or miss one address off. A segment placed at the top of the space checks that a wrapped limit does not produce a false hit at low addresses. Two overlapping segments check that the lowest index wins, so a design that picked the highest-numbered match would report the wrong slot and base. A write made in the same cycle as a lookup checks that the new contents do not leak into that lookup. A large pseudo-random sweep compares every response field with an arithmetic model.

// File: rtl/seg_xlate_pkg.sv
// Shared definitions for the segment translator.
// Assumes nothing beyond being compiled before the modules that import it.
package seg_xlate_pkg;

    // Kind of the registered response held at the output.
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_kind_e;

endpackage

// File: rtl/seg_table.sv
// Descriptor storage: NUM_SEG slots, each holding valid, start, bound, base.
// Assumes a single write per cycle; a write becomes visible after the edge.
module seg_table #(
    parameter int NUM_SEG = 4,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic                           wr_valid,
    input  logic [ADDR_W-1:0]              wr_start,
    input  logic [ADDR_W-1:0]              wr_bound,
    input  logic [ADDR_W-1:0]              wr_base,
    output logic [NUM_SEG-1:0]             tbl_vld,
    output logic [NUM_SEG-1:0][ADDR_W-1:0] tbl_start,
    output logic [NUM_SEG-1:0][ADDR_W-1:0] tbl_bound,
    output logic [NUM_SEG-1:0][ADDR_W-1:0] tbl_base
);

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_slot
        // Purpose: clear the slot on reset, load it when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_vld[g]   <= 1'b0;
                tbl_start[g] <= '0;
                tbl_bound[g] <= '0;
                tbl_base[g]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                tbl_vld[g]   <= wr_valid;
                tbl_start[g] <= wr_start;
                tbl_bound[g] <= wr_bound;
                tbl_base[g]  <= wr_base;
            end
        end
    end

    // R10: a write lands in the addressed slot with the written fields.
    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_start[$past(wr_idx)] == $past(wr_start)) &&
                  (tbl_base[$past(wr_idx)]  == $past(wr_base))  &&
                  (tbl_vld[$past(wr_idx)]   == $past(wr_valid)));

    // R1: no descriptor is valid in the cycle right after reset.
    assert_reset_invalid_R1: assert property (@(posedge clk)
        !rst_n |=> (tbl_vld == '0));

endmodule

// File: rtl/seg_match.sv
// Parallel range checks: one comparator pair and one relocator per slot.
// Assumes the upper limit is built one bit wider so it cannot wrap.
module seg_match #(
    parameter int NUM_SEG = 4,
    parameter int ADDR_W  = 32
) (
    input  logic [ADDR_W-1:0]              va,
    input  logic [NUM_SEG-1:0]             tbl_vld,
    input  logic [NUM_SEG-1:0][ADDR_W-1:0] tbl_start,
    input  logic [NUM_SEG-1:0][ADDR_W-1:0] tbl_bound,
    input  logic [NUM_SEG-1:0][ADDR_W-1:0] tbl_base,
    output logic [NUM_SEG-1:0]             hit,
    output logic [NUM_SEG-1:0][ADDR_W-1:0] pa
);

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_cmp
        logic [ADDR_W:0] limit;
        logic            above_lo;
        logic            below_hi;

        // Purpose: wide end address, inclusive low / exclusive high test.
        always_comb begin
            limit    = {1'b0, tbl_start[g]} + {1'b0, tbl_bound[g]};
            above_lo = (va >= tbl_start[g]);
            below_hi = ({1'b0, va} < limit);
            hit[g]   = tbl_vld[g] && above_lo && below_hi;
            pa[g]    = va - tbl_start[g] + tbl_base[g];
        end
    end

endmodule

// File: rtl/seg_select.sv
// Fixed-priority pick among matching slots; the lowest index wins.
// Assumes hit and pa come from the same lookup.
module seg_select #(
    parameter int NUM_SEG = 4,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SEG-1:0]             hit,
    input  logic [NUM_SEG-1:0][ADDR_W-1:0] pa,
    output logic                           any_hit,
    output logic [IDX_W-1:0]               sel_idx,
    output logic [ADDR_W-1:0]              sel_pa
);

    logic [NUM_SEG-1:0] grant;

    // Purpose: scan from the top so the lowest matching slot is written last.
    always_comb begin
        any_hit = 1'b0;
        sel_idx = '0;
        sel_pa  = '0;
        grant   = '0;
        for (int i = NUM_SEG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit  = 1'b1;
                sel_idx  = IDX_W'(i);
                sel_pa   = pa[i];
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    // R7: at most one slot is granted.
    assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7: slot 0 wins whenever it matches.
    assert_low_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |-> (grant[0] && sel_idx == '0));

endmodule

// File: rtl/seg_xlate.sv
// Segment translator top: descriptor table, parallel matcher, priority
// select and a registered response one cycle after each request.
// Assumes requests may arrive every cycle; there is no back-pressure.
module seg_xlate #(
    parameter int NUM_SEG = 4,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_start,
    input  logic [ADDR_W-1:0] wr_bound,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [ADDR_W-1:0] rsp_fault_vaddr,
    output logic [IDX_W-1:0]  rsp_seg
);
    import seg_xlate_pkg::*;

    logic [NUM_SEG-1:0]             tbl_vld;
    logic [NUM_SEG-1:0][ADDR_W-1:0] tbl_start;
    logic [NUM_SEG-1:0][ADDR_W-1:0] tbl_bound;
    logic [NUM_SEG-1:0][ADDR_W-1:0] tbl_base;
    logic [NUM_SEG-1:0]             hit;
    logic [NUM_SEG-1:0][ADDR_W-1:0] pa;
    logic                           any_hit;
    logic [IDX_W-1:0]               sel_idx;
    logic [ADDR_W-1:0]              sel_pa;

    rsp_kind_e         kind_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [ADDR_W-1:0] fvaddr_q;
    logic [IDX_W-1:0]  seg_q;

    seg_table #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_valid  (wr_valid),
        .wr_start  (wr_start),
        .wr_bound  (wr_bound),
        .wr_base   (wr_base),
        .tbl_vld   (tbl_vld),
        .tbl_start (tbl_start),
        .tbl_bound (tbl_bound),
        .tbl_base  (tbl_base)
    );

    seg_match #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) u_match (
        .va        (req_vaddr),
        .tbl_vld   (tbl_vld),
        .tbl_start (tbl_start),
        .tbl_bound (tbl_bound),
        .tbl_base  (tbl_base),
        .hit       (hit),
        .pa        (pa)
    );

    seg_select #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) u_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .pa      (pa),
        .any_hit (any_hit),
        .sel_idx (sel_idx),
        .sel_pa  (sel_pa)
    );

    // Purpose: capture the lookup result, or clear the response when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            kind_q   <= RSP_IDLE;
            paddr_q  <= '0;
            fvaddr_q <= '0;
            seg_q    <= '0;
        end else if (any_hit) begin
            kind_q   <= RSP_HIT;
            paddr_q  <= sel_pa;
            fvaddr_q <= '0;
            seg_q    <= sel_idx;
        end else begin
            kind_q   <= RSP_MISS;
            paddr_q  <= '0;
            fvaddr_q <= req_vaddr;
            seg_q    <= '0;
        end
    end

    assign rsp_valid       = (kind_q != RSP_IDLE);
    assign rsp_fault       = (kind_q == RSP_MISS);
    assign rsp_paddr       = paddr_q;
    assign rsp_fault_vaddr = fvaddr_q;
    assign rsp_seg         = seg_q;

    // R2: every request gets a response on the next cycle.
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: an idle cycle leaves the response quiet.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_paddr == '0));

    // R8: a fault carries a zero physical address and the requested address.
    assert_fault_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0 && rsp_fault_vaddr == $past(req_vaddr)));

    // R4: a hit never reports a faulting address.
    assert_hit_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_fault_vaddr == '0));

endmodule

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
    localparam int NS = 4;
    localparam int AW = 32;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_start = '0, wr_bound = '0, wr_base = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_vaddr = '0;
    logic          rsp_valid, rsp_fault;
    logic [AW-1:0] rsp_paddr, rsp_fault_vaddr;
    logic [IW-1:0] rsp_seg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic          m_vld   [NS];
    logic [AW-1:0] m_start [NS];
    logic [AW-1:0] m_bound [NS];
    logic [AW-1:0] m_base  [NS];

    always #2.5 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_start(wr_start), .wr_bound(wr_bound),
        .wr_base(wr_base), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_fault_vaddr(rsp_fault_vaddr), .rsp_seg(rsp_seg)
    );

    // Arithmetic model built from the requirements.
    task automatic model(input logic [AW-1:0] va, output logic f,
                         output logic [AW-1:0] pa, output logic [IW-1:0] idx);
        f = 1'b1; pa = '0; idx = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            logic [AW:0] lim;
            lim = {1'b0, m_start[i]} + {1'b0, m_bound[i]};
            if (m_vld[i] && va >= m_start[i] && {1'b0, va} < lim) begin
                f = 1'b0; pa = va - m_start[i] + m_base[i]; idx = IW'(i);
            end
        end
    endtask

    task automatic check_rsp(input string req, input logic [AW-1:0] va,
                             input logic ef, input logic [AW-1:0] epa,
                             input logic [IW-1:0] eidx);
        logic [AW-1:0] efv;
        efv = ef ? va : '0;
        n_tests++;
        if (rsp_valid !== 1'b1 || rsp_fault !== ef || rsp_paddr !== epa ||
            rsp_fault_vaddr !== efv || rsp_seg !== eidx) begin
            n_fail++;
            $display("FAIL %s va=%h got v=%b f=%b pa=%h fv=%h seg=%0d exp v=1 f=%b pa=%h fv=%h seg=%0d",
                     req, va, rsp_valid, rsp_fault, rsp_paddr, rsp_fault_vaddr,
                     rsp_seg, ef, epa, efv, eidx);
        end
    endtask

    task automatic lookup(input string req, input logic [AW-1:0] va);
        logic f; logic [AW-1:0] pa; logic [IW-1:0] idx;
        model(va, f, pa, idx);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = '0;
        check_rsp(req, va, f, pa, idx);
    endtask

    task automatic write_seg(input int i, input logic v, input logic [AW-1:0] s,
                             input logic [AW-1:0] b, input logic [AW-1:0] base);
        wr_en = 1'b1; wr_idx = IW'(i); wr_valid = v;
        wr_start = s; wr_bound = b; wr_base = base;
        @(negedge clk);
        wr_en = 1'b0;
        m_vld[i] = v; m_start[i] = s; m_bound[i] = b; m_base[i] = base;
    endtask

    task automatic probe_edges(input string req, input int i);
        lookup(req, m_start[i] - 1);
        lookup(req, m_start[i]);
        lookup(req, m_start[i] + 1);
        lookup(req, m_start[i] + (m_bound[i] >> 1));
        lookup(req, m_start[i] + m_bound[i] - 1);
        lookup(req, m_start[i] + m_bound[i]);
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_vld[i] = 1'b0; m_start[i] = '0; m_bound[i] = '0; m_base[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset.
        n_tests++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_paddr !== '0 || rsp_seg !== '0) begin
            n_fail++;
            $display("FAIL R1 reset outputs got v=%b f=%b pa=%h exp all zero",
                     rsp_valid, rsp_fault, rsp_paddr);
        end
        rst_n = 1'b1;
        @(negedge clk);
        lookup("R1 empty table", 32'h0000_0000);
        lookup("R1 empty table", 32'h1234_5678);

        write_seg(0, 1'b1, 32'h1000_0000, 32'h0000_1000, 32'h0056_7000);
        write_seg(1, 1'b1, 32'h2000_0000, 32'h0010_0000, 32'h8000_0000);
        write_seg(2, 1'b1, 32'h2008_0000, 32'h0010_0000, 32'h4000_0000);
        write_seg(3, 1'b1, 32'hFFFF_F000, 32'h0000_2000, 32'h0000_1000);

        probe_edges("R3 R4 edges seg0", 0);
        probe_edges("R7 overlap seg1", 1);
        probe_edges("R7 overlap seg2", 2);
        lookup("R5 top segment", 32'hFFFF_F000);
        lookup("R5 top segment", 32'hFFFF_FFFF);
        lookup("R5 no wrap", 32'h0000_0000);
        lookup("R5 no wrap", 32'h0000_0FFF);
        lookup("R8 miss", 32'h0000_0800);
        lookup("R8 miss", 32'h7FFF_FFFF);

        // R2: an idle cycle after a response drops rsp_valid.
        @(negedge clk);
        n_tests++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_paddr !== '0 || rsp_fault_vaddr !== '0) begin
            n_fail++;
            $display("FAIL R2 idle got v=%b f=%b pa=%h exp all zero", rsp_valid, rsp_fault, rsp_paddr);
        end

        // R6: invalid slot ignored, overlapping slot 2 takes over.
        write_seg(1, 1'b0, 32'h2000_0000, 32'h0010_0000, 32'h8000_0000);
        lookup("R6 invalid slot", 32'h2000_0000);
        lookup("R6 invalid slot", 32'h2008_0000);

        // R3: zero bound covers nothing.
        write_seg(1, 1'b1, 32'h3000_0000, 32'h0000_0000, 32'h0000_0000);
        lookup("R3 zero bound", 32'h3000_0000);

        // R9: base-and-bound through slot 0 with start 0.
        write_seg(0, 1'b1, 32'h0000_0000, 32'h0000_4000, 32'h0030_0000);
        lookup("R9 base bound", 32'h0000_0000);
        lookup("R9 base bound", 32'h0000_3FFF);
        lookup("R9 base bound", 32'h0000_4000);

        // R10: same-cycle write is not seen, next cycle is.
        begin
            logic f; logic [AW-1:0] pa; logic [IW-1:0] idx;
            model(32'h0000_1000, f, pa, idx);
            wr_en = 1'b1; wr_idx = 2'd0; wr_valid = 1'b1;
            wr_start = 32'h0000_0000; wr_bound = 32'h0000_4000; wr_base = 32'h0900_0000;
            req_valid = 1'b1; req_vaddr = 32'h0000_1000;
            @(negedge clk);
            wr_en = 1'b0; req_valid = 1'b0;
            check_rsp("R10 same cycle old view", 32'h0000_1000, f, pa, idx);
            m_base[0] = 32'h0900_0000;
        end
        lookup("R10 next cycle new view", 32'h0000_1000);
        lookup("R10 others unchanged", 32'h2008_0000);

        // R3 R4 R7: pseudo-random sweep near and away from segments.
        write_seg(1, 1'b1, 32'h2000_0000, 32'h0010_0000, 32'h8000_0000);
        begin
            logic [AW-1:0] lfsr;
            lfsr = 32'hACE1_1234;
            for (int k = 0; k < 600; k++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                if (k % 3 == 0)
                    lookup("R4 random sweep", lfsr);
                else
                    lookup("R3 near sweep",
                           m_start[k % NS] - 32'h100 + (lfsr % (m_bound[k % NS] + 32'h200)));
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule